// File: doc/BRIEF.md
# Embedded-Clock Deserializer Lock Tracker

This block takes a serial bit stream that has already been sampled at the right phase. One bit arrives on each cycle that has the bit-clock enable asserted. The stream is cut into 20-bit frames. Each frame opens with a high start bit, carries 18 payload bits, and closes with a low stop bit. The low-to-high change from a stop bit to the next start bit serves as the embedded clock edge. The block hunts for that edge, confirms it at a fixed 20-bit spacing, and declares lock. From then on it delivers one 18-bit word per frame, marked by a one-cycle strobe.

While locked, the block checks every frame for the edge. One missing edge is tolerated. A second consecutive miss drops lock, and the block goes back to hunting by itself. The lock indication is active low. A separate output enable blanks the word and strobe outputs without disturbing lock tracking. Power-down, or a local reference that is not yet ready, clears the block and holds it idle.

Top module: `lkt_deser`

## Requirements
- R1: In search, a candidate boundary is accepted only when a 0-to-1 change (previous enabled bit 0, current bit 1) is seen at the same position in 3 consecutive 20-bit frames. Until then `lock_n` stays 1 and `word_stb` stays 0.
- R2: `lock_n` is active low. Whenever `lock_n` is 1, `word_out` reads all zeros.
- R3: `lock_n` falls on the same clock as the first `word_stb` after acquisition. It stays 1 while the start bit of the accepting frame is processed.
- R4: Bit order within a frame is start bit, then payload bits, then stop bit. The first payload bit after the start bit lands in `word_out[0]` and the last lands in `word_out[17]`. `word_stb` is high for exactly one clock, on the clock after the enable that carries the last payload bit, once per frame.
- R5: While locked, one frame whose start position lacks the edge still delivers its word and keeps `lock_n` low. The next good edge clears the miss count.
- R6: Two consecutive frames with the edge missing drop lock. `lock_n` is 1 on the clock after the enable carrying the second missing start position, and that frame delivers no strobe.
- R7: After loss of lock, the block searches again by itself and relocks after 3 good frames, with no outside action.
- R8: While `out_en` is 0, `word_out` is zero and `word_stb` is 0, but `lock_n` keeps tracking. When `out_en` returns to 1, words resume on the next frame.
- R9: While `pwr_dn` is 1 or `ref_ok` is 0, all state clears and `lock_n` is 1 on the next clock. After release, a full 3-frame acquisition is needed.
- R10: A candidate whose edge is missing 20 bits later is abandoned. The search then moves on one bit position at a time until a new edge is found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down: clears the block and holds it idle |
| ref_ok | input | 1 | Local reference ready; 0 holds the block idle |
| bit_en | input | 1 | Bit-clock enable; one serial bit per assertion |
| bit_in | input | 1 | Serial data bit, already phase-aligned |
| out_en | input | 1 | Output enable for `word_out` and `word_stb` |
| word_out | output | 18 | Recovered payload word, zero when blanked or unlocked |
| word_stb | output | 1 | One-clock pulse per delivered word |
| lock_n | output | 1 | Lock indication, active low |

## Verification
Every result here sits one register behind the enable that causes it. The strobe and the word appear on the clock after the enable carrying the 18th payload bit. `lock_n` falls on that same clock, and it rises on the clock after the enable at the second missing start position. Power-down and reference loss show on `lock_n` one clock after they are applied. The bench drives each bit at a falling edge and keeps the enable high for one rising edge only. It samples all outputs at the very next falling edge, so each check reads the value due from exactly that bit.

// File: rtl/lkt_pkg.sv
package lkt_pkg;
    typedef enum logic {
        MODE_SEEK  = 1'b0,
        MODE_TRACK = 1'b1
    } lkt_mode_e;
endpackage

// File: rtl/lkt_rise.sv
// Remembers the last enabled bit and flags a 0-to-1 change on the current bit.
module lkt_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_en,
    input  logic bit_in,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (clr)         prev_d = 1'b1;
        else if (bit_en) prev_d = bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise = ~prev_q & bit_in;
endmodule

// File: rtl/lkt_shreg.sv
// Collects payload bits, newest at the top.
module lkt_shreg #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] sh_q
);
    logic [W-1:0] sh_d;

    always_comb begin
        sh_d = sh_q;
        if (clr)        sh_d = '0;
        else if (shift) sh_d = {bit_in, sh_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/lkt_deser.sv
module lkt_deser
    import lkt_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int ACQ_HITS = 3,
    parameter int MISS_MAX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              ref_ok,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              out_en,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              lock_n
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam int HIT_W   = $clog2(ACQ_HITS + 1);
    localparam int MISS_W  = $clog2(MISS_MAX + 1);
    localparam logic [POS_W-1:0]  POS_LAST = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0]  POS_DATA = POS_W'(DATA_W);
    localparam logic [HIT_W-1:0]  HIT_TOP  = HIT_W'(ACQ_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_MAX - 1);

    typedef struct packed {
        lkt_mode_e         mode;
        logic [POS_W-1:0]  pos;
        logic [HIT_W-1:0]  hits;
        logic [MISS_W-1:0] miss;
        logic              lock_n;
        logic              stb;
        logic [DATA_W-1:0] word;
    } lkt_state_t;

    localparam lkt_state_t ST_RESET = '{
        mode: MODE_SEEK, pos: '0, hits: '0, miss: '0,
        lock_n: 1'b1, stb: 1'b0, word: '0
    };

    lkt_state_t        st_d, st_q;
    logic              idle;
    logic              rise;
    logic              shift_en;
    logic [DATA_W-2:0] sh_q;

    assign idle = pwr_dn | ~ref_ok;

    lkt_rise u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (idle),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .rise   (rise)
    );

    lkt_shreg #(.W(DATA_W - 1)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (idle),
        .shift  (shift_en),
        .bit_in (bit_in),
        .sh_q   (sh_q)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        shift_en = 1'b0;
        if (idle) begin
            st_d = ST_RESET;
        end else if (bit_en) begin
            unique case (st_q.mode)
                MODE_SEEK: begin
                    if (st_q.pos == '0) begin
                        if (rise) begin
                            st_d.pos = POS_W'(1);
                            if (st_q.hits == HIT_TOP) begin
                                st_d.mode = MODE_TRACK;
                                st_d.hits = '0;
                                st_d.miss = '0;
                            end else begin
                                st_d.hits = st_q.hits + 1'b1;
                            end
                        end else begin
                            // candidate fails: try the very next bit
                            st_d.hits = '0;
                        end
                    end else begin
                        st_d.pos = (st_q.pos == POS_LAST) ? '0 : st_q.pos + 1'b1;
                    end
                end
                MODE_TRACK: begin
                    st_d.pos = (st_q.pos == POS_LAST) ? '0 : st_q.pos + 1'b1;
                    if (st_q.pos == '0) begin
                        if (rise) begin
                            st_d.miss = '0;
                        end else if (st_q.miss == MISS_TOP) begin
                            st_d.mode   = MODE_SEEK;
                            st_d.pos    = '0;
                            st_d.hits   = '0;
                            st_d.miss   = '0;
                            st_d.lock_n = 1'b1;
                        end else begin
                            st_d.miss = st_q.miss + 1'b1;
                        end
                    end else if (st_q.pos == POS_DATA) begin
                        st_d.word   = {bit_in, sh_q};
                        st_d.stb    = 1'b1;
                        st_d.lock_n = 1'b0;
                    end else if (st_q.pos < POS_DATA) begin
                        shift_en = 1'b1;
                    end
                end
                default: st_d = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign lock_n   = st_q.lock_n;
    assign word_stb = st_q.stb & out_en;
    assign word_out = (out_en && !st_q.lock_n) ? st_q.word : '0;
endmodule

// File: rtl/lkt_deser_chk.sv
module lkt_deser_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_dn,
    input logic              ref_ok,
    input logic              bit_en,
    input logic              out_en,
    input logic [DATA_W-1:0] word_out,
    input logic              word_stb,
    input logic              lock_n
);
    a_r2_blank_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n |-> (word_out == '0));

    a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    a_r4_stb_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> $past(bit_en));

    a_r3_lock_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> (word_stb || !out_en));

    a_r9_idle_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn || !ref_ok) |=> (lock_n && !word_stb));
endmodule

bind lkt_deser lkt_deser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .ref_ok   (ref_ok),
    .bit_en   (bit_en),
    .out_en   (out_en),
    .word_out (word_out),
    .word_stb (word_stb),
    .lock_n   (lock_n)
);

// File: tb/lkt_deser_test.sv
`timescale 1ns/1ps
module lkt_deser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        ref_ok = 1'b1;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        out_en = 1'b1;
    logic [17:0] word_out;
    logic        word_stb;
    logic        lock_n;

    logic        s_lock, s_stb;
    logic [17:0] s_word;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lkt_deser uut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ref_ok(ref_ok),
        .bit_en(bit_en), .bit_in(bit_in), .out_en(out_en),
        .word_out(word_out), .word_stb(word_stb), .lock_n(lock_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        s_lock = lock_n;
        s_stb  = word_stb;
        s_word = word_out;
        @(negedge clk);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    // start bit, payload LSB first, stop bit; checks after start and after last payload bit
    task automatic send_frame(input logic [17:0] d, input logic st, input logic ln_early,
                              input logic exp_stb, input logic ln_late, input string tag);
        send_bit(st);
        check(s_lock == ln_early, {tag, " lock_n after start"}, s_lock, ln_early);
        for (int i = 0; i < 18; i++) send_bit(d[i]);
        check(s_stb == exp_stb, {tag, " word_stb"}, s_stb, exp_stb);
        check(s_lock == ln_late, {tag, " lock_n at word"}, s_lock, ln_late);
        if (exp_stb)
            check(s_word == d, {tag, " word_out"}, s_word, d);
        else if (ln_late || !out_en)
            check(s_word == '0, {tag, " word_out blank"}, s_word, 0);
        send_bit(1'b0);
    endtask

    task automatic t_reset;
        check(lock_n == 1'b1, "R2 reset lock_n", lock_n, 1);
        check(word_stb == 1'b0, "R2 reset word_stb", word_stb, 0);
        check(word_out == '0, "R2 reset word_out", word_out, 0);
    endtask

    task automatic t_acquire;
        send_zeros(5);
        send_frame(18'h15555, 1'b1, 1'b1, 1'b0, 1'b1, "R1 frame1");
        send_frame(18'h0F0F0, 1'b1, 1'b1, 1'b0, 1'b1, "R1 frame2");
        send_frame(18'h2D2B1, 1'b1, 1'b1, 1'b1, 1'b0, "R3 frame3");
    endtask

    task automatic t_patterns;
        send_frame(18'h00001, 1'b1, 1'b0, 1'b1, 1'b0, "R4 lsb");
        send_frame(18'h20000, 1'b1, 1'b0, 1'b1, 1'b0, "R4 msb");
        send_frame(18'h3FFFF, 1'b1, 1'b0, 1'b1, 1'b0, "R4 ones");
        send_frame(18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b0, "R4 alt");
    endtask

    task automatic t_single_miss;
        send_frame(18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, "R5 miss1");
        send_frame(18'h12345, 1'b1, 1'b0, 1'b1, 1'b0, "R5 good");
        send_frame(18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, "R5 miss again");
        send_frame(18'h0BEEF, 1'b1, 1'b0, 1'b1, 1'b0, "R5 good2");
    endtask

    task automatic t_loss;
        send_frame(18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, "R6 first miss");
        send_frame(18'h00000, 1'b0, 1'b1, 1'b0, 1'b1, "R6 second miss");
    endtask

    task automatic t_relock;
        send_frame(18'h1C3C3, 1'b1, 1'b1, 1'b0, 1'b1, "R7 frame1");
        send_frame(18'h0A5A5, 1'b1, 1'b1, 1'b0, 1'b1, "R7 frame2");
        send_frame(18'h33CC3, 1'b1, 1'b1, 1'b1, 1'b0, "R7 frame3");
    endtask

    task automatic t_out_en;
        out_en = 1'b0;
        send_frame(18'h3A5C7, 1'b1, 1'b0, 1'b0, 1'b0, "R8 gated");
        out_en = 1'b1;
        send_frame(18'h05A3C, 1'b1, 1'b0, 1'b1, 1'b0, "R8 resumed");
    endtask

    task automatic t_power_down;
        pwr_dn = 1'b1;
        @(negedge clk);
        check(lock_n == 1'b1, "R9 pwr_dn lock_n", lock_n, 1);
        check(word_out == '0, "R9 pwr_dn word_out", word_out, 0);
        pwr_dn = 1'b0;
        @(negedge clk);
        // false candidate: a 0-to-1 change with no edge 20 bits on
        send_bit(1'b0);
        send_bit(1'b1);
        send_zeros(30);
        send_frame(18'h11111, 1'b1, 1'b1, 1'b0, 1'b1, "R10 frame1");
        send_frame(18'h22222, 1'b1, 1'b1, 1'b0, 1'b1, "R10 frame2");
        send_frame(18'h0C0C0, 1'b1, 1'b1, 1'b1, 1'b0, "R10 frame3");
    endtask

    task automatic t_ref_loss;
        ref_ok = 1'b0;
        @(negedge clk);
        check(lock_n == 1'b1, "R9 ref_ok lock_n", lock_n, 1);
        ref_ok = 1'b1;
        @(negedge clk);
        send_zeros(3);
        send_frame(18'h3F000, 1'b1, 1'b1, 1'b0, 1'b1, "R9 reacq1");
        send_frame(18'h00FC0, 1'b1, 1'b1, 1'b0, 1'b1, "R9 reacq2");
        send_frame(18'h2468A, 1'b1, 1'b1, 1'b1, 1'b0, "R9 reacq3");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_acquire();
        t_patterns();
        t_single_miss();
        t_loss();
        t_relock();
        t_out_en();
        t_power_down();
        t_ref_loss();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule